// File: doc/BRIEF.md
# Block-Compressed Path History Register

This block keeps the speculative global history that a branch predictor uses for one hardware thread. It does not add one bit per conditional branch. It adds at most one bit per fetch block. That bit is the outcome of the last conditional branch in the block XORed with bit 4 of that branch's address. Folding an address bit into the outcome spreads the history patterns more evenly across the predictor tables, because optimized code has far more not-taken branches than taken ones.

The predictor read is pipelined, so a lookup cannot wait for the outcomes of the blocks still in flight ahead of it. The block therefore presents a history that is deliberately aged by three fetch blocks. Next to it, it presents the start addresses of the three most recent fetch blocks, and these carry the path information that the aged history lacks. Up to two fetch-block records arrive per cycle. When a misprediction occurs, one cycle of snapshot load replaces both the aged history and the three in-flight block entries.

Top module: `blkhist_reg`

## Requirements
- R1: After reset, `idx_hist` is all zeros and the three path-address outputs are zero.
- R2: A valid record whose `has_br` flag is 1 contributes exactly one history bit, however many branches the block holds.
- R3: The contributed bit equals `taken` XOR bit 4 of `br_pc`. A taken value of 1 means taken.
- R4: A valid record whose `has_br` flag is 0 contributes no history bit. Its block address still enters the path outputs.
- R5: The bit of a block appears in `idx_hist` only once three further valid records have been accepted after it.
- R6: Each new bit enters `idx_hist` at bit 0. The older bits move one place up, and the bit at position HIST_W-1 (20 by default) is discarded.
- R7: `path_addr0` is the block address of the most recent valid record, `path_addr1` the one before it, and `path_addr2` the one before that.
- R8: When both records are valid in one cycle, slot 0 is treated as older than slot 1. Slot 1 alone may also carry a record.
- R9: A record whose valid flag is 0 changes neither the history nor the path outputs.
- R10: When `restore_en` is 1, the next state loads `restore_hist` as the aged history. Snapshot entry k (0 = newest) takes `restore_has[k]`, `restore_bit[k]` and `restore_addrk`.
- R11: A restore overrides any records presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec0_valid | input | 1 | Slot 0 record present (older slot) |
| rec0_has_br | input | 1 | Slot 0 block holds a conditional branch |
| rec0_taken | input | 1 | Outcome of slot 0's last conditional branch |
| rec0_br_pc | input | ADDR_W | Address of slot 0's last conditional branch |
| rec0_blk_addr | input | ADDR_W | Start address of slot 0's fetch block |
| rec1_valid | input | 1 | Slot 1 record present (younger slot) |
| rec1_has_br | input | 1 | Slot 1 block holds a conditional branch |
| rec1_taken | input | 1 | Outcome of slot 1's last conditional branch |
| rec1_br_pc | input | ADDR_W | Address of slot 1's last conditional branch |
| rec1_blk_addr | input | ADDR_W | Start address of slot 1's fetch block |
| restore_en | input | 1 | Load snapshot this cycle |
| restore_hist | input | HIST_W | Snapshot aged history |
| restore_has | input | 3 | Snapshot branch-present flags, index 0 newest |
| restore_bit | input | 3 | Snapshot compressed bits, index 0 newest |
| restore_addr0 | input | ADDR_W | Snapshot newest block address |
| restore_addr1 | input | ADDR_W | Snapshot middle block address |
| restore_addr2 | input | ADDR_W | Snapshot oldest block address |
| idx_hist | output | HIST_W | History aged by three fetch blocks |
| path_addr0 | output | ADDR_W | Most recent block address |
| path_addr1 | output | ADDR_W | Second most recent block address |
| path_addr2 | output | ADDR_W | Third most recent block address |

## Verification
The hardest condition to reach is the one where an entry leaves the three-block window and shifts into the aged history, while the entry being pushed out is a branchless block or comes from a snapshot. This case tests the delay and the no-bit rule together. The stimulus reaches it in three ways. First, branchless and invalid records are mixed into the vector table at different distances from branch blocks. Second, a long run of single branch records drives the 21-bit history past its width. Third, a restore that holds a branch-bearing oldest entry is followed by one new block, so the snapshot bit must appear in `idx_hist` right away.

// File: rtl/blkhist_reg.sv
module blkhist_reg #(
  parameter int HIST_W = 21,
  parameter int ADDR_W = 32,
  parameter int PC_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec0_valid,
  input  logic              rec0_has_br,
  input  logic              rec0_taken,
  input  logic [ADDR_W-1:0] rec0_br_pc,
  input  logic [ADDR_W-1:0] rec0_blk_addr,
  input  logic              rec1_valid,
  input  logic              rec1_has_br,
  input  logic              rec1_taken,
  input  logic [ADDR_W-1:0] rec1_br_pc,
  input  logic [ADDR_W-1:0] rec1_blk_addr,
  input  logic              restore_en,
  input  logic [HIST_W-1:0] restore_hist,
  input  logic [2:0]        restore_has,
  input  logic [2:0]        restore_bit,
  input  logic [ADDR_W-1:0] restore_addr0,
  input  logic [ADDR_W-1:0] restore_addr1,
  input  logic [ADDR_W-1:0] restore_addr2,
  output logic [HIST_W-1:0] idx_hist,
  output logic [ADDR_W-1:0] path_addr0,
  output logic [ADDR_W-1:0] path_addr1,
  output logic [ADDR_W-1:0] path_addr2
);

  logic [HIST_W-1:0] aged_q, aged_d;
  logic [2:0]        has_q, has_d, bit_q, bit_d;
  logic [ADDR_W-1:0] addr_q [3];
  logic [ADDR_W-1:0] addr_d [3];

  logic [1:0]        in_v, in_has, in_bit;
  logic [ADDR_W-1:0] in_addr [2];

  assign in_v    = {rec1_valid, rec0_valid};
  assign in_has  = {rec1_has_br, rec0_has_br};
  assign in_bit  = {rec1_has_br & (rec1_taken ^ rec1_br_pc[PC_BIT]),
                    rec0_has_br & (rec0_taken ^ rec0_br_pc[PC_BIT])};
  assign in_addr[0] = rec0_blk_addr;
  assign in_addr[1] = rec1_blk_addr;

  always_comb begin
    aged_d = aged_q;
    has_d  = has_q;
    bit_d  = bit_q;
    addr_d = addr_q;
    for (int s = 0; s < 2; s++) begin
      if (in_v[s]) begin
        if (has_d[2]) aged_d = {aged_d[HIST_W-2:0], bit_d[2]};
        has_d     = {has_d[1:0], in_has[s]};
        bit_d     = {bit_d[1:0], in_bit[s]};
        addr_d[2] = addr_d[1];
        addr_d[1] = addr_d[0];
        addr_d[0] = in_addr[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aged_q <= '0;
      has_q  <= '0;
      bit_q  <= '0;
      for (int k = 0; k < 3; k++) addr_q[k] <= '0;
    end else if (restore_en) begin
      aged_q    <= restore_hist;
      has_q     <= restore_has;
      bit_q     <= restore_bit & restore_has;
      addr_q[0] <= restore_addr0;
      addr_q[1] <= restore_addr1;
      addr_q[2] <= restore_addr2;
    end else begin
      aged_q <= aged_d;
      has_q  <= has_d;
      bit_q  <= bit_d;
      addr_q <= addr_d;
    end
  end

  assign idx_hist   = aged_q;
  assign path_addr0 = addr_q[0];
  assign path_addr1 = addr_q[1];
  assign path_addr2 = addr_q[2];

endmodule

// File: rtl/blkhist_reg_chk.sv
module blkhist_reg_chk #(
  parameter int HIST_W = 21,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec0_valid,
  input logic [ADDR_W-1:0] rec0_blk_addr,
  input logic              rec1_valid,
  input logic [ADDR_W-1:0] rec1_blk_addr,
  input logic              restore_en,
  input logic [HIST_W-1:0] restore_hist,
  input logic [ADDR_W-1:0] restore_addr0,
  input logic [ADDR_W-1:0] restore_addr2,
  input logic [HIST_W-1:0] idx_hist,
  input logic [ADDR_W-1:0] path_addr0,
  input logic [ADDR_W-1:0] path_addr1,
  input logic [ADDR_W-1:0] path_addr2
);

  // R10
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> idx_hist == $past(restore_hist) && path_addr0 == $past(restore_addr0)
                   && path_addr2 == $past(restore_addr2));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec0_valid && !rec1_valid && !restore_en) |=>
      $stable(idx_hist) && $stable(path_addr0) && $stable(path_addr1) && $stable(path_addr2));

  // R7
  one_block_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec0_valid && !rec1_valid && !restore_en) |=>
      path_addr0 == $past(rec0_blk_addr) && path_addr1 == $past(path_addr0)
      && path_addr2 == $past(path_addr1));

  // R8
  two_block_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec0_valid && rec1_valid && !restore_en) |=>
      path_addr0 == $past(rec1_blk_addr) && path_addr1 == $past(rec0_blk_addr)
      && path_addr2 == $past(path_addr0));

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_en |=> (idx_hist == $past(idx_hist))
      || (idx_hist[HIST_W-1:1] == $past(idx_hist[HIST_W-2:0]))
      || (idx_hist[HIST_W-1:2] == $past(idx_hist[HIST_W-3:0])));

endmodule

bind blkhist_reg blkhist_reg_chk #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rec0_valid(rec0_valid), .rec0_blk_addr(rec0_blk_addr),
  .rec1_valid(rec1_valid), .rec1_blk_addr(rec1_blk_addr),
  .restore_en(restore_en), .restore_hist(restore_hist),
  .restore_addr0(restore_addr0), .restore_addr2(restore_addr2),
  .idx_hist(idx_hist), .path_addr0(path_addr0),
  .path_addr1(path_addr1), .path_addr2(path_addr2)
);

// File: tb/tb_blkhist_reg.sv
module tb_blkhist_reg;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 21;
  localparam int AW = 32;
  localparam int NVEC = 12;

  // each entry {slot1, slot0}; a slot is {valid, has_br, taken, pc[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {11'h000, 11'h710}, {11'h700, 11'h600}, {11'h000, 11'h420}, {11'h610, 11'h000},
    {11'h718, 11'h734}, {11'h000, 11'h3FF}, {11'h444, 11'h62C}, {11'h75C, 11'h708},
    {11'h600, 11'h610}, {11'h000, 11'h770}, {11'h000, 11'h000}, {11'h7F3, 11'h701}
  };

  logic clk = 0, rst_n = 0;
  logic r0v = 0, r0h = 0, r0t = 0, r1v = 0, r1h = 0, r1t = 0;
  logic [AW-1:0] r0pc = 0, r0ba = 0, r1pc = 0, r1ba = 0;
  logic rs_en = 0;
  logic [HW-1:0] rs_hist = 0;
  logic [2:0] rs_has = 0, rs_bit = 0;
  logic [AW-1:0] rs_a0 = 0, rs_a1 = 0, rs_a2 = 0;
  logic [HW-1:0] idx_hist;
  logic [AW-1:0] pa0, pa1, pa2;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [HW-1:0] base;
  logic mh [256];
  logic mb [256];
  logic [AW-1:0] ma [256];
  int n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkhist_reg dut (
    .clk(clk), .rst_n(rst_n),
    .rec0_valid(r0v), .rec0_has_br(r0h), .rec0_taken(r0t), .rec0_br_pc(r0pc), .rec0_blk_addr(r0ba),
    .rec1_valid(r1v), .rec1_has_br(r1h), .rec1_taken(r1t), .rec1_br_pc(r1pc), .rec1_blk_addr(r1ba),
    .restore_en(rs_en), .restore_hist(rs_hist), .restore_has(rs_has), .restore_bit(rs_bit),
    .restore_addr0(rs_a0), .restore_addr1(rs_a1), .restore_addr2(rs_a2),
    .idx_hist(idx_hist), .path_addr0(pa0), .path_addr1(pa1), .path_addr2(pa2)
  );

  function automatic logic [AW-1:0] blk_of(logic [7:0] pc);
    return {16'h0, 8'h5A, pc};
  endfunction

  task automatic model_add(logic h, logic t, logic [7:0] pc);
    mh[n] = h;
    mb[n] = t ^ pc[4];
    ma[n] = blk_of(pc);
    n++;
  endtask

  task automatic compare(string tag);
    logic [HW-1:0] eh;
    logic [AW-1:0] e0, e1, e2;
    eh = base;
    for (int i = 0; i <= n - 4; i++) if (mh[i]) eh = {eh[HW-2:0], mb[i]};
    e0 = (n >= 1) ? ma[n-1] : '0;
    e1 = (n >= 2) ? ma[n-2] : '0;
    e2 = (n >= 3) ? ma[n-3] : '0;
    checks++;
    if (idx_hist !== eh || pa0 !== e0 || pa1 !== e1 || pa2 !== e2) begin
      errors++;
      $display("FAIL %s: hist=%h p=%h/%h/%h expected hist=%h p=%h/%h/%h",
               tag, idx_hist, pa0, pa1, pa2, eh, e0, e1, e2);
    end
  endtask

  task automatic drive(logic [10:0] s0, logic [10:0] s1);
    r0v = s0[10]; r0h = s0[9]; r0t = s0[8]; r0pc = {24'h0, s0[7:0]}; r0ba = blk_of(s0[7:0]);
    r1v = s1[10]; r1h = s1[9]; r1t = s1[8]; r1pc = {24'h0, s1[7:0]}; r1ba = blk_of(s1[7:0]);
    @(negedge clk);
    if (!rs_en) begin
      if (s0[10]) model_add(s0[9], s0[8], s0[7:0]);
      if (s1[10]) model_add(s1[9], s1[8], s1[7:0]);
    end
    r0v = 0; r1v = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset zeros");

    // R2 R3 R4 R5 R7 R8 R9: table walk
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][10:0], VEC[v][21:11]);
      compare($sformatf("R2/R3/R4/R5/R7/R8/R9 vector %0d", v));
    end

    // R6: fill past the history width with single branch records
    for (int i = 0; i < 30; i++) begin
      drive({3'b110 | {2'b0, i[0]}, i[7:0] * 8'd8 + 8'd3}, 11'h000);
      compare($sformatf("R6 overflow step %0d", i));
    end

    // R9: invalid records carrying branches leave everything unchanged
    drive(11'h3FF, 11'h3EF);
    compare("R9 invalid pair ignored");

    // R10 R11: restore with competing records in the same cycle
    rs_en = 1; rs_hist = 21'h15A5C3; rs_has = 3'b101; rs_bit = 3'b100;
    rs_a0 = 32'hAAAA0000; rs_a1 = 32'hBBBB0000; rs_a2 = 32'hCCCC0000;
    drive(11'h710, 11'h720);
    rs_en = 0;
    base = rs_hist; n = 3;
    mh[0] = 1; mb[0] = 1; ma[0] = rs_a2;
    mh[1] = 0; mb[1] = 0; ma[1] = rs_a1;
    mh[2] = 1; mb[2] = 0; ma[2] = rs_a0;
    compare("R10/R11 restore wins over records");
    drive(11'h420, 11'h000);
    compare("R10 snapshot oldest bit enters history");
    drive(11'h400, 11'h000);
    compare("R4 snapshot branchless entry leaves no bit");

    // R1: reset from a populated state
    rst_n = 0;
    @(negedge clk);
    base = '0; n = 0;
    compare("R1 reset mid-run");
    rst_n = 1;
    @(negedge clk);
    compare("R1 state held after release");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule